// File: doc/BRIEF.md
# Radix-8 Booth Complex Multiplier

This block forms the product of a complex data sample and a complex twiddle factor, as needed after a butterfly in an FFT processing element. The sample is (a_re, a_im) and the twiddle is (b_re, b_im), all signed two's-complement W-bit values. The result is the full-precision complex product, 2W+1 bits per part, so no bits are lost and no rounding is applied.

Each of the four real products is built by a radix-8 Booth multiplier. The twiddle part is the recoded operand: it is sign-extended to a multiple of three bits and cut into overlapping four-bit windows, with a zero below the LSB. Each window becomes a digit from -4 to +4. The sample part is the multiplicand. Its triple is made once with one adder, and the other multiples come from shifts and negation. All partial products are formed and summed at the same time in one combinational stage.

A valid/ready handshake on each side lets the block stall under back-pressure. The pipeline is two register stages deep: the first holds the four real products and the second holds the complex result. It accepts one operand set per cycle when the output is free.

Top module: `booth8_cmul`

## Requirements
- R1: out_re equals a_re*b_re - a_im*b_im exactly, as a signed (2W+1)-bit value.
- R2: out_im equals a_re*b_im + a_im*b_re exactly, as a signed (2W+1)-bit value.
- R3: Operands at the most negative value -2^(W-1) or at the most positive value give exact results. For example, all four inputs at -2^(W-1) give out_re = 0 and out_im = 2^(2W-1).
- R4: An operand set is accepted at a rising edge where in_valid and in_ready are both 1. With out_ready held at 1, out_valid is 0 after that edge and is 1 with that result after the next edge.
- R5: in_ready is 1 when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, in_ready is 0 and out_re, out_im and out_valid hold their values. On the cycle out_ready returns to 1, a result drains and a new operand set is accepted at the same edge.
- R6: After a synchronous reset (rst high at a clock edge), out_valid is 0 and in_ready is 1.
- R7: With out_ready held at 1, operand sets can be presented on consecutive cycles, and their results come out on consecutive cycles in the order they went in.
- R8: Operand values presented while in_valid is 0 produce no result: out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set |
| a_re | input | W | Sample real part, signed |
| a_im | input | W | Sample imaginary part, signed |
| b_re | input | W | Twiddle real part, signed |
| b_im | input | W | Twiddle imaginary part, signed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_re | output | 2W+1 | Product real part, signed |
| out_im | output | 2W+1 | Product imaginary part, signed |

## Verification
Two events can fall on the same edge: a stalled result drains, and a new operand set enters the first stage. To provoke this, the bench stalls the output while one set waits in the first stage and another is held at the input with in_valid high. It then raises out_ready. The check is that both waiting sets come out in order on the next two cycles, that neither is duplicated or lost, and that the held set was not taken during the stall.

// File: rtl/booth8_cmul.sv
module booth8_cmul #(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic signed [W-1:0]   a_re,
  input  logic signed [W-1:0]   a_im,
  input  logic signed [W-1:0]   b_re,
  input  logic signed [W-1:0]   b_im,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic signed [2*W:0]   out_re,
  output logic signed [2*W:0]   out_im
);
  localparam int NG = (W + 2) / 3;
  localparam int YW = 3 * NG;
  localparam int PW = 2 * W;
  localparam int OW = 2 * W + 1;

  function automatic logic [3:0] recode(input logic [3:0] g);
    case (g)
      4'b0001, 4'b0010: recode = 4'b0001;
      4'b0011, 4'b0100: recode = 4'b0010;
      4'b0101, 4'b0110: recode = 4'b0011;
      4'b0111:          recode = 4'b0100;
      4'b1000:          recode = 4'b1100;
      4'b1001, 4'b1010: recode = 4'b1011;
      4'b1011, 4'b1100: recode = 4'b1010;
      4'b1101, 4'b1110: recode = 4'b1001;
      default:          recode = 4'b0000;
    endcase
  endfunction

  function automatic logic signed [PW-1:0] bmul(
    input logic signed [PW-1:0] x1,
    input logic signed [PW-1:0] x3,
    input logic [4*NG-1:0]      d
  );
    logic signed [PW-1:0] s;
    logic signed [PW-1:0] m;
    s = '0;
    for (int i = 0; i < NG; i++) begin
      case (d[4*i +: 3])
        3'd1:    m = x1;
        3'd2:    m = x1 <<< 1;
        3'd3:    m = x3;
        3'd4:    m = x1 <<< 2;
        default: m = '0;
      endcase
      if (d[4*i+3]) m = -m;
      s = s + (m <<< (3 * i));
    end
    return s;
  endfunction

  logic en, acc;
  assign en       = !out_valid || out_ready;
  assign in_ready = en;
  assign acc      = in_valid && en;

  logic signed [PW-1:0] xr1, xr3, xi1, xi3;
  assign xr1 = PW'(a_re);
  assign xi1 = PW'(a_im);
  assign xr3 = xr1 + (xr1 <<< 1);
  assign xi3 = xi1 + (xi1 <<< 1);

  logic signed [YW-1:0] ybr, ybi;
  logic [YW:0]          wbr, wbi;
  logic [4*NG-1:0]      dbr, dbi;
  assign ybr = YW'(b_re);
  assign ybi = YW'(b_im);
  assign wbr = {ybr, 1'b0};
  assign wbi = {ybi, 1'b0};

  for (genvar i = 0; i < NG; i++) begin : g_rec
    assign dbr[4*i +: 4] = recode(wbr[3*i +: 4]);
    assign dbi[4*i +: 4] = recode(wbi[3*i +: 4]);
  end

  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic                 v1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      p_rr <= '0;
      p_ii <= '0;
      p_ri <= '0;
      p_ir <= '0;
    end else if (en) begin
      v1 <= in_valid;
      if (in_valid) begin
        p_rr <= bmul(xr1, xr3, dbr);
        p_ii <= bmul(xi1, xi3, dbi);
        p_ri <= bmul(xr1, xr3, dbi);
        p_ir <= bmul(xi1, xi3, dbr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (en) begin
      out_valid <= v1;
      if (v1) begin
        out_re <= OW'(p_rr) - OW'(p_ii);
        out_im <= OW'(p_ri) + OW'(p_ir);
      end
    end
  end
endmodule

module booth8_cmul_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic signed [W-1:0] a_re,
  input logic signed [W-1:0] a_im,
  input logic signed [W-1:0] b_re,
  input logic signed [W-1:0] b_im,
  input logic                out_valid,
  input logic                out_ready,
  input logic signed [2*W:0] out_re,
  input logic signed [2*W:0] out_im
);
  localparam int OW = 2 * W + 1;

  logic signed [W-1:0] d1_ar, d1_ai, d1_br, d1_bi;
  logic signed [W-1:0] d2_ar, d2_ai, d2_br, d2_bi;
  logic a1, a2, r1;

  always_ff @(posedge clk) begin
    if (rst) begin
      {d1_ar, d1_ai, d1_br, d1_bi} <= '0;
      {d2_ar, d2_ai, d2_br, d2_bi} <= '0;
      a1 <= 1'b0;
      a2 <= 1'b0;
      r1 <= 1'b0;
    end else begin
      {d1_ar, d1_ai, d1_br, d1_bi} <= {a_re, a_im, b_re, b_im};
      {d2_ar, d2_ai, d2_br, d2_bi} <= {d1_ar, d1_ai, d1_br, d1_bi};
      a1 <= in_valid && in_ready;
      a2 <= a1;
      r1 <= in_ready;
    end
  end

  logic signed [OW-1:0] ref_re, ref_im;
  always_comb begin
    ref_re = OW'(d2_ar) * OW'(d2_br) - OW'(d2_ai) * OW'(d2_bi);
    ref_im = OW'(d2_ar) * OW'(d2_bi) + OW'(d2_ai) * OW'(d2_br);
  end

  // R1
  re_value_chk: assert property (@(posedge clk) disable iff (rst)
    (a2 && r1) |-> out_re == ref_re);

  // R2
  im_value_chk: assert property (@(posedge clk) disable iff (rst)
    (a2 && r1) |-> out_im == ref_im);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (a1 && in_ready) |=> out_valid);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

  // R5
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R5
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid || out_ready) |-> in_ready);
endmodule

bind booth8_cmul booth8_cmul_chk #(.W(W)) u_chk (.*);

// File: tb/sim_booth8_cmul.sv
`timescale 1ns/1ps
module sim_booth8_cmul;
  localparam int W = 16;
  localparam int MN = -32768;
  localparam int MX = 32767;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [W-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic in_ready, out_valid;
  logic signed [2*W:0] out_re, out_im;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  booth8_cmul #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ere(input int ar, input int ai, input int br, input int bi);
    return longint'(ar) * br - longint'(ai) * bi;
  endfunction

  function automatic longint eim(input int ar, input int ai, input int br, input int bi);
    return longint'(ar) * bi + longint'(ai) * br;
  endfunction

  task automatic drive(input int ar, input int ai, input int br, input int bi);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    in_valid = 1'b1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 out_valid after reset", out_valid, 0);
    check("R6 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_single(input string req, input int ar, input int ai, input int br, input int bi);
    out_ready = 1'b1;
    drive(ar, ai, br, bi);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R4 not yet valid"}, out_valid, 0);
    @(negedge clk);
    check({req, " R4 valid"}, out_valid, 1);
    check({req, " R1 re"}, longint'(out_re), ere(ar, ai, br, bi));
    check({req, " R2 im"}, longint'(out_im), eim(ar, ai, br, bi));
    @(negedge clk);
  endtask

  task automatic t_stream(input int n, input bit use_rand);
    int sa[64], sb[64], sc[64], sd[64];
    for (int i = 0; i < n; i++) begin
      if (use_rand) begin
        sa[i] = int'(16'($urandom)) - ((($urandom & 1) == 0) ? 0 : 0);
        sa[i] = (sa[i] > MX) ? sa[i] - 65536 : sa[i];
        sb[i] = int'($urandom % 65536) - 32768;
        sc[i] = int'($urandom % 65536) - 32768;
        sd[i] = int'($urandom % 65536) - 32768;
      end else begin
        sa[i] = (i % 3 == 0) ? MN : ((i % 3 == 1) ? MX : -1);
        sb[i] = (i % 2 == 0) ? MX : MN;
        sc[i] = (i % 4 < 2) ? MN : MX;
        sd[i] = (i % 5 == 0) ? 0 : MN;
      end
    end
    out_ready = 1'b1;
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R7 stream valid", out_valid, 1);
        check("R1 stream re", longint'(out_re), ere(sa[i-2], sb[i-2], sc[i-2], sd[i-2]));
        check("R2 stream im", longint'(out_im), eim(sa[i-2], sb[i-2], sc[i-2], sd[i-2]));
      end
      if (i < n) drive(sa[i], sb[i], sc[i], sd[i]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R7 stream end", out_valid, 0);
  endtask

  task automatic t_backpressure();
    out_ready = 1'b0;
    drive(1000, -2000, 3000, 4000);
    @(negedge clk);
    drive(-7, 11, MN, 13);
    @(negedge clk);
    drive(MX, MN, -5, 9);
    check("R5 stalled valid", out_valid, 1);
    for (int k = 0; k < 3; k++) begin
      check("R5 stalled in_ready", in_ready, 0);
      check("R5 held re", longint'(out_re), ere(1000, -2000, 3000, 4000));
      check("R5 held im", longint'(out_im), eim(1000, -2000, 3000, 4000));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check("R5 ready on release", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 drain second valid", out_valid, 1);
    check("R5 drain second re", longint'(out_re), ere(-7, 11, MN, 13));
    check("R5 drain second im", longint'(out_im), eim(-7, 11, MN, 13));
    @(negedge clk);
    check("R5 same-edge accept valid", out_valid, 1);
    check("R5 same-edge accept re", longint'(out_re), ere(MX, MN, -5, 9));
    check("R5 same-edge accept im", longint'(out_im), eim(MX, MN, -5, 9));
    @(negedge clk);
    check("R5 no extra result", out_valid, 0);
  endtask

  task automatic t_ignore();
    out_ready = 1'b1;
    in_valid = 1'b0;
    a_re = 16'sh1234; a_im = 16'sh7777; b_re = 16'sh8000; b_im = 16'sh0101;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 idle inputs ignored", out_valid, 0);
      a_re = a_re + 16'sd3;
    end
  endtask

  initial begin
    t_reset();
    t_single("R1R2 basic", 3, 4, 5, -6);
    t_single("R1R2 signs", -123, 456, -789, -1011);
    t_single("R3 all min", MN, MN, MN, MN);
    check("R3 all min re literal", longint'(out_re), 0);
    t_single("R3 min by min", MN, 0, MN, 0);
    t_single("R3 max by min", MX, MX, MN, MN);
    t_single("R3 mixed", MN, MX, MX, MN);
    t_single("R3 max all", MX, MX, MX, MX);
    t_single("R3 minus one", -1, -1, MN, MX);
    t_stream(32, 1'b0);
    for (int b = 0; b < 8; b++) t_stream(64, 1'b1);
    t_backpressure();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule